// File: doc/BRIEF.md
# SPI Master with Hardware Chip-Select

This block is an SPI master shift engine that also drives the active-low chip-select line itself. A set of static control inputs chooses whether the master is enabled, whether it drives the select line, whether it drops the select line high for a short gap between frames, and how far the system clock is divided down to make SCK. Bytes to send arrive on a valid/ready handshake. Each received byte leaves with a one-cycle strobe.

The select line follows the enable input, not the individual transfers. While the master is enabled and drives the select line, the line is held low. It is pulled high only for a one-SCK-period gap between two frames that run back to back, and only when gap mode is chosen. When the enable is cleared, the output enable of the select pad is released, so the pin floats instead of being driven high.

When the master does not drive the select line, the line is watched as an input so that several masters can share the bus. If another master pulls it low, the block raises a sticky mode-fault flag. It then stops driving SCK and MOSI and drops back to slave mode, where the line works as an active-low select input. The flag stays set until it is cleared by a pulse on the clear input.

Top module: `spi_csmaster`

## Requirements
- R1: After reset, sck, busy, rx_valid, modf, tx_ready and nss_oe are all 0.
- R2: While cfg_enable=1, cfg_ssoe=1 and modf=0, nss_oe is 1 and nss_out is 0 at every point except a pulse gap. With cfg_pulse=0, nss_out stays 0 across frames sent back to back.
- R3: When cfg_enable is 0, nss_oe is 0 in the same cycle, so the select pin is released to high impedance.
- R4: A frame is 8 bits, MSB first, with SCK idle low. MOSI holds the first bit before the first rising SCK edge and changes only on falling edges. MISO is sampled on each rising edge.
- R5: The SCK period is 2^(cfg_presc+1) system clocks: 8 clocks for cfg_presc=2 and 2 clocks for cfg_presc=0.
- R6: With cfg_pulse=1, when the next byte is already waiting as a frame ends, nss_out goes high for exactly one SCK period with SCK low, and then the next frame starts. If no byte is waiting, no pulse is produced.
- R7: busy is 1 from the cycle after a byte is accepted until the last falling SCK edge of the frame. SCK is never high while busy is 0.
- R8: rx_valid is high for exactly one cycle after the eighth sampling edge and the closing falling edge. In that cycle rx_data holds the received byte, MSB first.
- R9: With cfg_enable=1 and cfg_ssoe=0, a low on nss_in sets modf within 3 clocks. modf stays set, even after nss_in returns high, until modf_clear is pulsed. With cfg_ssoe=1, nss_in is ignored.
- R10: While modf=1, slave_mode is 1, tx_ready and mosi are 0, SCK is held low from the next cycle, and slave_sel is the synchronised inverse of nss_in.
- R11: tx_ready is 1 only while the master is enabled without a fault and the engine can take a byte: when idle, at the end of a frame with cfg_pulse=0, or at the end of a pulse gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Master enable |
| cfg_ssoe | input | 1 | 1: drive the select line; 0: watch it for mode faults |
| cfg_pulse | input | 1 | Insert a select-high gap between back-to-back frames |
| cfg_presc | input | 3 | SCK divider exponent, period 2^(n+1) clocks |
| modf_clear | input | 1 | Pulse to clear the sticky mode-fault flag |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Byte accepted on this clock when tx_valid is also 1 |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | A frame is shifting |
| modf | output | 1 | Sticky mode-fault flag |
| slave_mode | output | 1 | Block has dropped back to slave mode |
| slave_sel | output | 1 | In slave mode, select line seen low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_out | output | 1 | Select line output value |
| nss_oe | output | 1 | Select line output enable; 0 means high impedance |
| nss_in | input | 1 | Select line as seen at the pad |

## Verification
The assertions check, on every cycle, the rules that relate signals to one another. SCK stays low outside a frame and during a fault. The select pad is released whenever the master is disabled. A select-high pulse appears only in a gap with SCK low. The fault flag holds until it is cleared, and it can never rise while the block drives the line. rx_valid never lasts two cycles. Only the bench scenarios can show the values and timing across a whole frame: the MSB-first bit order in both directions, the SCK period for each divider setting, the exact 8-clock length of the select pulse, and that no pulse appears when no byte is waiting.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_t;

  // Number of system clocks in one SCK half period for divider exponent p.
  function automatic int unsigned half_period(input int unsigned p);
    return 32'd1 << p;
  endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int PRESC_W = 3,
  localparam int CNT_W  = 2 ** PRESC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               half_tick
);
  import spi_cs_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit     = CNT_W'(half_period(int'(presc)) - 1);
  assign half_tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (half_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample,
  input  logic              shift,
  input  logic              miso,
  output logic              tx_msb,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (load)  tx_q <= load_data;
    else if (shift) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (sample) rx_q <= {rx_q[DATA_W-2:0], miso};
  end

  assign tx_msb  = tx_q[DATA_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_select_ctrl.sv
module spi_select_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_enable,
  input  logic cfg_ssoe,
  input  logic modf_clear,
  input  logic nss_in,
  input  logic gap_active,
  output logic modf,
  output logic master_en,
  output logic nss_out,
  output logic nss_oe,
  output logic slave_sel
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   nss_seen;
  logic                   modf_q;
  logic                   fault_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], nss_in};
  end
  assign nss_seen = sync_q[SYNC_STAGES-1];

  // Another master pulled the shared line low while we only listen to it.
  assign fault_hit = cfg_enable && !cfg_ssoe && !nss_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          modf_q <= 1'b0;
    else if (fault_hit)  modf_q <= 1'b1;
    else if (modf_clear) modf_q <= 1'b0;
  end

  assign modf      = modf_q;
  assign master_en = cfg_enable && !modf_q;
  assign nss_oe    = master_en && cfg_ssoe;
  assign nss_out   = gap_active;
  assign slave_sel = modf_q && !nss_seen;
endmodule

// File: rtl/spi_csmaster.sv
module spi_csmaster #(
  parameter int DATA_W      = 8,
  parameter int PRESC_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_ssoe,
  input  logic               cfg_pulse,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic               modf_clear,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               busy,
  output logic               modf,
  output logic               slave_mode,
  output logic               slave_sel,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic               nss_out,
  output logic               nss_oe,
  input  logic               nss_in
);
  import spi_cs_pkg::*;

  localparam int HALF_N = 2 * DATA_W;
  localparam int HW     = $clog2(HALF_N);

  eng_state_t    st_q;
  logic [HW-1:0] half_q;
  logic          sck_q;
  logic          rx_valid_q;
  logic          master_en;
  logic          half_tick;
  logic          last_half;
  logic          gap_last;
  logic          accept;
  logic          sample_ev;
  logic          shift_ev;
  logic          frame_done;
  logic          gap_active;
  logic          tx_msb;

  assign last_half  = (half_q == HW'(HALF_N - 1));
  assign gap_last   = (half_q == HW'(1));
  assign gap_active = (st_q == ST_GAP);
  assign busy       = (st_q == ST_SHIFT);

  assign frame_done = master_en && busy && half_tick && last_half;
  assign sample_ev  = master_en && busy && half_tick && !half_q[0];
  assign shift_ev   = master_en && busy && half_tick && half_q[0] && !last_half;

  assign tx_ready = master_en &&
                    ((st_q == ST_IDLE) ||
                     (frame_done && !cfg_pulse) ||
                     (gap_active && half_tick && gap_last));
  assign accept   = tx_valid && tx_ready;

  spi_clkgen #(.PRESC_W(PRESC_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (master_en && (st_q != ST_IDLE)),
    .presc     (cfg_presc),
    .half_tick (half_tick)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .sample    (sample_ev),
    .shift     (shift_ev),
    .miso      (miso),
    .tx_msb    (tx_msb),
    .rx_byte   (rx_data)
  );

  spi_select_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_ssoe   (cfg_ssoe),
    .modf_clear (modf_clear),
    .nss_in     (nss_in),
    .gap_active (gap_active),
    .modf       (modf),
    .master_en  (master_en),
    .nss_out    (nss_out),
    .nss_oe     (nss_oe),
    .slave_sel  (slave_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      sck_q  <= 1'b0;
    end else if (!master_en) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          half_q <= '0;
          if (accept) st_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (half_tick) begin
            sck_q <= !half_q[0];
            if (last_half) begin
              half_q <= '0;
              if (accept)                    st_q <= ST_SHIFT;
              else if (tx_valid && cfg_pulse) st_q <= ST_GAP;
              else                           st_q <= ST_IDLE;
            end else begin
              half_q <= half_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (half_tick) begin
            if (gap_last) begin
              half_q <= '0;
              st_q   <= accept ? ST_SHIFT : ST_IDLE;
            end else begin
              half_q <= half_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_valid_q <= 1'b0;
    else        rx_valid_q <= frame_done;
  end

  assign rx_valid   = rx_valid_q;
  assign sck        = sck_q;
  assign mosi       = master_en && tx_msb;
  assign slave_mode = modf;
endmodule

// File: rtl/spi_csmaster_chk.sv
module spi_csmaster_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_ssoe,
  input logic modf_clear,
  input logic tx_ready,
  input logic rx_valid,
  input logic busy,
  input logic modf,
  input logic sck,
  input logic mosi,
  input logic nss_out,
  input logic nss_oe
);
  assert_sck_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_pad_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !nss_oe);

  assert_pulse_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nss_oe && nss_out) |-> (!busy && !sck));

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(modf) && !$past(modf_clear)) |-> modf);

  assert_no_fault_when_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !$past(cfg_ssoe));

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    modf |-> (!tx_ready && !mosi && !nss_oe));

  assert_fault_sck_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && $past(modf)) |-> !sck);

  assert_rx_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rx_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));
endmodule

bind spi_csmaster spi_csmaster_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .cfg_ssoe   (cfg_ssoe),
  .modf_clear (modf_clear),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .busy       (busy),
  .modf       (modf),
  .sck        (sck),
  .mosi       (mosi),
  .nss_out    (nss_out),
  .nss_oe     (nss_oe)
);

// File: tb/spi_csmaster_bench.sv
module spi_csmaster_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_ssoe = 1'b0, cfg_pulse = 1'b0;
  logic [2:0] cfg_presc = 3'd2;
  logic       modf_clear = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, rx_valid, busy, modf, slave_mode, slave_sel;
  logic [7:0] rx_data;
  logic       sck, mosi, nss_out, nss_oe;
  logic       miso;
  logic       nss_in = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  spi_csmaster u_spi_csmaster (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ssoe(cfg_ssoe),
    .cfg_pulse(cfg_pulse), .cfg_presc(cfg_presc), .modf_clear(modf_clear),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .modf(modf),
    .slave_mode(slave_mode), .slave_sel(slave_sel), .sck(sck), .mosi(mosi),
    .miso(miso), .nss_out(nss_out), .nss_oe(nss_oe), .nss_in(nss_in)
  );

  // Bench-side SPI slave: shifts out on falling SCK, captures MOSI on rising SCK.
  logic [15:0] miso_sh = 16'h0;
  logic [15:0] mosi_cap = 16'h0;
  assign miso = miso_sh[15];
  always @(negedge sck) miso_sh <= {miso_sh[14:0], 1'b0};
  always @(posedge sck) mosi_cap <= {mosi_cap[14:0], mosi};

  // Monitors sampled away from the active edge.
  int   cyc = 0, rises = 0, last_rise = 0, period = 0;
  int   nss_hi_cyc = 0, nss_pulses = 0, rx_cnt = 0, rx_wide = 0;
  int   sck_idle_hi = 0, busy_cyc = 0;
  logic sck_prev = 1'b0, nss_prev = 1'b0, rxv_prev = 1'b0;
  logic [7:0] rx_last = 8'h0, rx_prev = 8'h0;
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_prev) begin
      rises++;
      period = cyc - last_rise;
      last_rise = cyc;
    end
    if (nss_oe && nss_out) nss_hi_cyc++;
    if (nss_oe && nss_out && !nss_prev) nss_pulses++;
    if (rx_valid) begin
      rx_cnt++;
      rx_prev = rx_last;
      rx_last = rx_data;
      if (rxv_prev) rx_wide++;
    end
    if (sck && !busy) sck_idle_hi++;
    if (busy) busy_cyc++;
    sck_prev = sck;
    nss_prev = nss_oe && nss_out;
    rxv_prev = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    rises = 0; nss_hi_cyc = 0; nss_pulses = 0; rx_cnt = 0; rx_wide = 0;
    sck_idle_hi = 0; busy_cyc = 0; mosi_cap = 16'h0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int guard = 0;
    while (rx_cnt < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!sck && !busy && !rx_valid && !modf && !tx_ready && !nss_oe, "R1",
        {sck, busy, rx_valid, modf, tx_ready, nss_oe}, 0);
  endtask

  task automatic t_enable_low();
    cfg_enable = 1'b1; cfg_ssoe = 1'b1; cfg_pulse = 1'b0;
    repeat (2) @(negedge clk);
    chk(nss_oe && !nss_out, "R2 idle select low", {nss_oe, nss_out}, 2'b10);
    chk(tx_ready, "R11 ready when idle", tx_ready, 1);
  endtask

  task automatic t_single();
    clear_mon();
    miso_sh = {8'h3C, 8'h00};
    push(8'hA5);
    wait_rx(1);
    chk(mosi_cap[7:0] == 8'hA5, "R4 mosi MSB first", mosi_cap[7:0], 8'hA5);
    chk(rx_last == 8'h3C, "R8 rx byte", rx_last, 8'h3C);
    chk(rx_cnt == 1 && rx_wide == 0, "R8 one-cycle strobe", rx_cnt, 1);
    chk(rises == 8, "R4 eight rising edges", rises, 8);
    chk(period == 8, "R5 period div8", period, 8);
    chk(busy_cyc == 64, "R7 busy length", busy_cyc, 64);
    chk(sck_idle_hi == 0, "R7 sck low outside frame", sck_idle_hi, 0);
    chk(nss_hi_cyc == 0 && nss_oe, "R2 select held low", nss_hi_cyc, 0);
  endtask

  task automatic t_b2b_nopulse();
    clear_mon();
    miso_sh = 16'hC381;
    push(8'h5A);
    push(8'hF0);
    wait_rx(2);
    chk(mosi_cap == 16'h5AF0, "R4 two frames out", mosi_cap, 16'h5AF0);
    chk(rx_prev == 8'hC3 && rx_last == 8'h81, "R8 two frames in",
        {rx_prev, rx_last}, 16'hC381);
    chk(nss_pulses == 0, "R2 no pulse with pulse mode off", nss_pulses, 0);
    chk(busy_cyc == 128, "R11 ready at frame end, no idle gap", busy_cyc, 128);
  endtask

  task automatic t_b2b_pulse();
    cfg_pulse = 1'b1;
    clear_mon();
    miso_sh = 16'h1E77;
    push(8'h96);
    push(8'h0F);
    wait_rx(2);
    chk(nss_pulses == 1, "R6 one pulse", nss_pulses, 1);
    chk(nss_hi_cyc == 8, "R6 pulse one SCK period", nss_hi_cyc, 8);
    chk(mosi_cap == 16'h960F, "R6 frames intact around pulse", mosi_cap, 16'h960F);
    chk(rx_prev == 8'h1E && rx_last == 8'h77, "R6 rx around pulse",
        {rx_prev, rx_last}, 16'h1E77);
  endtask

  task automatic t_pulse_single();
    clear_mon();
    miso_sh = 16'h0;
    push(8'h42);
    wait_rx(1);
    repeat (20) @(negedge clk);
    chk(nss_pulses == 0 && nss_hi_cyc == 0, "R6 no pulse without waiting byte",
        nss_hi_cyc, 0);
    cfg_pulse = 1'b0;
  endtask

  task automatic t_fast();
    cfg_presc = 3'd0;
    clear_mon();
    miso_sh = {8'hE7, 8'h00};
    push(8'h81);
    wait_rx(1);
    chk(period == 2, "R5 period div2", period, 2);
    chk(rx_last == 8'hE7 && mosi_cap[7:0] == 8'h81, "R4 fast frame",
        {rx_last, mosi_cap[7:0]}, 16'hE781);
    cfg_presc = 3'd2;
  endtask

  task automatic t_disable();
    @(negedge clk);
    cfg_enable = 1'b0;
    #1;
    chk(!nss_oe, "R3 pad released on disable", nss_oe, 0);
    chk(!tx_ready, "R11 no ready when disabled", tx_ready, 0);
  endtask

  task automatic t_ssoe_ignores_nss();
    cfg_enable = 1'b1; cfg_ssoe = 1'b1;
    @(negedge clk);
    nss_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(!modf && nss_oe, "R9 nss_in ignored when driving", modf, 0);
    nss_in = 1'b1;
    repeat (3) @(negedge clk);
    cfg_enable = 1'b0;
  endtask

  task automatic t_modf();
    cfg_ssoe = 1'b0; cfg_enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(!modf && tx_ready, "R11 multimaster idle ready", modf, 0);
    clear_mon();
    miso_sh = 16'h0;
    tx_data = 8'hFF; tx_valid = 1'b1;
    repeat (10) @(negedge clk);
    nss_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(modf, "R9 fault within 3 clocks", modf, 1);
    @(negedge clk);
    chk(slave_mode && !tx_ready && !mosi && !sck, "R10 master quiet",
        {slave_mode, tx_ready, mosi, sck}, 4'b1000);
    chk(slave_sel, "R10 selected while low", slave_sel, 1);
    tx_valid = 1'b0;
    nss_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(modf && !slave_sel, "R9 sticky after release", {modf, slave_sel}, 2'b10);
    chk(rx_cnt == 0, "R10 aborted frame gives no byte", rx_cnt, 0);
    modf_clear = 1'b1;
    @(negedge clk);
    modf_clear = 1'b0;
    @(negedge clk);
    chk(!modf && !slave_mode && tx_ready, "R9 clear restores master",
        {modf, slave_mode, tx_ready}, 3'b001);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_enable_low();
    t_single();
    t_b2b_nopulse();
    t_b2b_pulse();
    t_pulse_single();
    t_fast();
    t_disable();
    t_ssoe_ignores_nss();
    t_modf();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule